// File: doc/BRIEF.md
# Delay-Tap Phase Calibration Controller

This controller picks a fixed sampling delay for each of many serial receive lanes that share one clock source. While the far end sends a known training pattern, it steps a variable input delay through every tap setting. At each tap it judges capture through a per-lane pattern-match flag. For each lane it keeps the middle of the longest stretch of taps that capture without error, and stores that tap.

Lanes are handled one after another. The delay line is represented by a tap value and a lane select on the outputs. The controller waits a fixed number of cycles after each tap change before it looks at the match flag. Because the phase relation does not drift under a shared clock, a stored tap is kept until the next calibration. Any stored value, and a per-lane flag for lanes that never passed, can be read back at any time through a lane index.

Top module: `tapcal_ctrl`

## Requirements
- R1: After reset, done_o is low, cal_tap_o and cal_lane_o are 0, and every lane reads back tap 0 with its error flag clear.
- R2: A high start_i is accepted only while the controller is idle (not calibrating). Once accepted, calibration starts with lane 0 at tap 0. A start_i that arrives during calibration has no effect on the sequence.
- R3: Each tap is held for SETTLE_CYC cycles of settling and then for CHECK_CYC cycles of checking. A tap passes only if match_i of the lane being calibrated is high in every one of the CHECK_CYC check cycles.
- R4: Within a lane, cal_tap_o steps up by one from 0 to NUM_TAPS-1. Every tap takes SETTLE_CYC+CHECK_CYC cycles, and one store cycle follows the last tap.
- R5: The stored tap is the first tap of the longest run of consecutive passing taps plus half that run's length, rounded down. When two runs are equally long, the one with the lower taps wins.
- R6: A lane with no passing tap stores tap 0 and has its error flag set. A lane that passes has its error flag cleared.
- R7: Lanes are calibrated in ascending order from 0 to NUM_LANES-1. Only the match_i bit of the lane shown on cal_lane_o is used.
- R8: done_o rises in the cycle after the last lane is stored. It stays high until the next accepted start_i, and it goes low in the cycle after that start.
- R9: rd_tap_o and rd_err_o show, without a clock delay, the stored values of the lane selected by rd_lane_i. Stored values are kept until calibration writes that lane again.
- R10: A single low match_i sample during the check cycles of a tap fails that tap, which splits a passing run into two.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start a calibration pass over all lanes |
| match_i | input | NUM_LANES | Per-lane training-pattern match flag |
| cal_lane_o | output | LANE_W | Lane whose delay is currently being driven |
| cal_tap_o | output | TAP_W | Delay tap applied to that lane |
| done_o | output | 1 | All lanes calibrated; held until next start |
| rd_lane_i | input | LANE_W | Lane index for read-back |
| rd_tap_o | output | TAP_W | Stored tap of the selected lane |
| rd_err_o | output | 1 | Selected lane found no passing tap |

## Verification
The assertions assume that start_i and match_i are synchronous to clk. They also assume that match_i is meaningful only for the lane and tap shown on the outputs, and that rd_lane_i stays below NUM_LANES. The stimulus keeps to this. It drives match_i just after each falling edge from a per-lane pass map, indexed by the lane and tap that the model expects. It fills the bits of the other lanes with random values. It also pulses start_i in the middle of a sweep, to show that a start during calibration is refused at the edge rather than resolved at the port.

// File: rtl/tapcal_pkg.sv
package tapcal_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETTLE = 2'd1,
    ST_CHECK  = 2'd2,
    ST_STORE  = 2'd3
  } cal_state_e;
endpackage

// File: rtl/tapcal_window.sv
// Tracks the current run of passing taps and the longest run seen so far.
module tapcal_window #(
  parameter int TAP_W = 6,
  parameter int LEN_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             step_i,
  input  logic             pass_i,
  input  logic [TAP_W-1:0] tap_i,
  output logic [TAP_W-1:0] best_start_o,
  output logic [LEN_W-1:0] best_len_o
);
  logic [TAP_W-1:0] cur_start_q, cur_start_n, best_start_q, best_start_n;
  logic [LEN_W-1:0] cur_len_q, cur_len_n, best_len_q, best_len_n;

  always_comb begin
    cur_start_n  = cur_start_q;
    cur_len_n    = cur_len_q;
    best_start_n = best_start_q;
    best_len_n   = best_len_q;
    if (clear_i) begin
      cur_start_n  = '0;
      cur_len_n    = '0;
      best_start_n = '0;
      best_len_n   = '0;
    end else if (step_i) begin
      if (pass_i) begin
        if (cur_len_q == '0) cur_start_n = tap_i;
        cur_len_n = cur_len_q + 1'b1;
        // strict compare keeps the earlier run on a tie
        if (cur_len_n > best_len_q) begin
          best_start_n = cur_start_n;
          best_len_n   = cur_len_n;
        end
      end else begin
        cur_len_n = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_start_q  <= '0;
      cur_len_q    <= '0;
      best_start_q <= '0;
      best_len_q   <= '0;
    end else if (clear_i || step_i) begin
      cur_start_q  <= cur_start_n;
      cur_len_q    <= cur_len_n;
      best_start_q <= best_start_n;
      best_len_q   <= best_len_n;
    end
  end

  assign best_start_o = best_start_q;
  assign best_len_o   = best_len_q;

  // R5: the best run only grows between clears
  p_best_grows_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !clear_i |=> best_len_q >= $past(best_len_q));
  // R5: the current run never exceeds the recorded best
  p_best_covers_cur_r5: assert property (@(posedge clk) disable iff (!rst_n)
    best_len_q >= cur_len_q);
endmodule

// File: rtl/tapcal_store.sv
// Per-lane tap and error storage with combinational read-back.
module tapcal_store #(
  parameter int NUM_LANES = 96,
  parameter int LANE_W    = 7,
  parameter int TAP_W     = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [LANE_W-1:0] wlane_i,
  input  logic [TAP_W-1:0]  wtap_i,
  input  logic              werr_i,
  input  logic [LANE_W-1:0] rd_lane_i,
  output logic [TAP_W-1:0]  rd_tap_o,
  output logic              rd_err_o
);
  logic [TAP_W-1:0] tap_q [NUM_LANES];
  logic             err_q [NUM_LANES];

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    logic wr_en;
    assign wr_en = we_i && (wlane_i == LANE_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        tap_q[g] <= '0;
        err_q[g] <= 1'b0;
      end else if (wr_en) begin
        tap_q[g] <= wtap_i;
        err_q[g] <= werr_i;
      end
    end
  end

  always_comb begin
    rd_tap_o = '0;
    rd_err_o = 1'b0;
    for (int i = 0; i < NUM_LANES; i++) begin
      if (rd_lane_i == LANE_W'(i)) begin
        rd_tap_o = tap_q[i];
        rd_err_o = err_q[i];
      end
    end
  end

  // R6: a failed lane is always written with tap 0
  p_err_tap_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && werr_i) |-> (wtap_i == '0));
endmodule

// File: rtl/tapcal_ctrl.sv
module tapcal_ctrl
  import tapcal_pkg::*;
#(
  parameter int NUM_LANES  = 96,
  parameter int NUM_TAPS   = 64,
  parameter int SETTLE_CYC = 8,
  parameter int CHECK_CYC  = 16,
  localparam int LANE_W    = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1,
  localparam int TAP_W     = (NUM_TAPS > 1) ? $clog2(NUM_TAPS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_i,
  input  logic [NUM_LANES-1:0] match_i,
  output logic [LANE_W-1:0]    cal_lane_o,
  output logic [TAP_W-1:0]     cal_tap_o,
  output logic                 done_o,
  input  logic [LANE_W-1:0]    rd_lane_i,
  output logic [TAP_W-1:0]     rd_tap_o,
  output logic                 rd_err_o
);
  localparam int LEN_W   = $clog2(NUM_TAPS + 1);
  localparam int CNT_MAX = (SETTLE_CYC > CHECK_CYC) ? SETTLE_CYC : CHECK_CYC;
  localparam int CNT_W   = (CNT_MAX > 1) ? $clog2(CNT_MAX) : 1;

  cal_state_e        state_q, state_n;
  logic [LANE_W-1:0] lane_q, lane_n;
  logic [TAP_W-1:0]  tap_q, tap_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic              ok_q, ok_n, done_q, done_n;
  logic              seq_en;

  logic              lane_match, settle_last, check_last, tap_last, lane_last;
  logic              win_clear, win_step, store_we;
  logic [TAP_W-1:0]  best_start, sel_tap;
  logic [LEN_W-1:0]  best_len;
  logic              sel_err;

  assign lane_match  = match_i[lane_q];
  assign settle_last = (cnt_q == CNT_W'(SETTLE_CYC - 1));
  assign check_last  = (cnt_q == CNT_W'(CHECK_CYC - 1));
  assign tap_last    = (tap_q == TAP_W'(NUM_TAPS - 1));
  assign lane_last   = (lane_q == LANE_W'(NUM_LANES - 1));

  always_comb begin
    state_n   = state_q;
    lane_n    = lane_q;
    tap_n     = tap_q;
    cnt_n     = cnt_q;
    ok_n      = ok_q;
    done_n    = done_q;
    win_clear = 1'b0;
    win_step  = 1'b0;
    store_we  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_n   = ST_SETTLE;
          lane_n    = '0;
          tap_n     = '0;
          cnt_n     = '0;
          done_n    = 1'b0;
          win_clear = 1'b1;
        end
      end
      ST_SETTLE: begin
        if (settle_last) begin
          cnt_n   = '0;
          ok_n    = 1'b1;
          state_n = ST_CHECK;
        end else begin
          cnt_n = cnt_q + 1'b1;
        end
      end
      ST_CHECK: begin
        ok_n = ok_q & lane_match;
        if (check_last) begin
          win_step = 1'b1;
          cnt_n    = '0;
          if (tap_last) begin
            state_n = ST_STORE;
          end else begin
            tap_n   = tap_q + 1'b1;
            state_n = ST_SETTLE;
          end
        end else begin
          cnt_n = cnt_q + 1'b1;
        end
      end
      ST_STORE: begin
        store_we  = 1'b1;
        win_clear = 1'b1;
        if (lane_last) begin
          done_n  = 1'b1;
          state_n = ST_IDLE;
        end else begin
          lane_n  = lane_q + 1'b1;
          tap_n   = '0;
          state_n = ST_SETTLE;
        end
      end
      default: state_n = ST_IDLE;
    endcase
  end

  assign seq_en = (state_q != ST_IDLE) || start_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      lane_q  <= '0;
      tap_q   <= '0;
      cnt_q   <= '0;
      ok_q    <= 1'b0;
      done_q  <= 1'b0;
    end else if (seq_en) begin
      state_q <= state_n;
      lane_q  <= lane_n;
      tap_q   <= tap_n;
      cnt_q   <= cnt_n;
      ok_q    <= ok_n;
      done_q  <= done_n;
    end
  end

  tapcal_window #(.TAP_W(TAP_W), .LEN_W(LEN_W)) u_window (
    .clk          (clk),
    .rst_n        (rst_n),
    .clear_i      (win_clear),
    .step_i       (win_step),
    .pass_i       (ok_q & lane_match),
    .tap_i        (tap_q),
    .best_start_o (best_start),
    .best_len_o   (best_len)
  );

  assign sel_err = (best_len == '0);
  assign sel_tap = sel_err ? '0
                 : TAP_W'(LEN_W'(best_start) + (best_len >> 1));

  tapcal_store #(.NUM_LANES(NUM_LANES), .LANE_W(LANE_W), .TAP_W(TAP_W)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .we_i      (store_we),
    .wlane_i   (lane_q),
    .wtap_i    (sel_tap),
    .werr_i    (sel_err),
    .rd_lane_i (rd_lane_i),
    .rd_tap_o  (rd_tap_o),
    .rd_err_o  (rd_err_o)
  );

  assign cal_lane_o = lane_q;
  assign cal_tap_o  = tap_q;
  assign done_o     = done_q;

  // R2: with no start the idle state is kept
  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && !start_i) |=> state_q == ST_IDLE);
  // R3: the tap is not moved while it is being checked
  p_tap_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_CHECK && !check_last) |=> $stable(tap_q));
  // R4: the tap either steps by one or restarts at zero
  p_tap_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(tap_q) |-> (tap_q == $past(tap_q) + 1'b1) || (tap_q == '0));
  // R7: lanes advance one at a time after a store
  p_lane_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_STORE && !lane_last) |=> lane_q == $past(lane_q) + 1'b1);
  // R8: done holds until a start is seen
  p_done_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !start_i) |=> done_q);
  // R8: a start drops done
  p_done_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && start_i) |=> !done_q);
endmodule

// File: tb/tapcal_ctrl_tb.sv
module tapcal_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int L    = 4;
  localparam int TAPS = 64;
  localparam int SET  = 8;
  localparam int CHK  = 16;
  localparam int LW   = 2;
  localparam int TW   = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic [L-1:0]  match_i = '0;
  logic [LW-1:0] rd_lane_i = '0;
  logic [LW-1:0] cal_lane_o;
  logic [TW-1:0] cal_tap_o, rd_tap_o;
  logic          done_o, rd_err_o;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  logic [TAPS-1:0] pmap [L];
  bit g_en = 0;
  int g_lane = 0, g_tap = 0, g_cnt = 0;

  // behavioural model: 0 idle, 1 settle, 2 check, 3 store
  int m_state, m_cnt, m_tap, m_lane;
  bit m_done, m_ok;
  bit rec [TAPS];
  int exp_tap [L];
  bit exp_err [L];

  always #(CLK_PERIOD/2) clk = ~clk;

  tapcal_ctrl #(.NUM_LANES(L), .NUM_TAPS(TAPS), .SETTLE_CYC(SET), .CHECK_CYC(CHK)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .match_i(match_i),
    .cal_lane_o(cal_lane_o), .cal_tap_o(cal_tap_o), .done_o(done_o),
    .rd_lane_i(rd_lane_i), .rd_tap_o(rd_tap_o), .rd_err_o(rd_err_o));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit drive_bit();
    bit b;
    b = pmap[m_lane][m_tap];
    if (g_en && g_lane == m_lane && g_tap == m_tap && m_state == 2 && m_cnt == g_cnt) b = 0;
    return b;
  endfunction

  task automatic pick_best(output int tap, output bit err);
    int i, s, len, bl, bs;
    bl = 0; bs = 0; i = 0;
    while (i < TAPS) begin
      if (rec[i]) begin
        s = i;
        while (i < TAPS && rec[i]) i++;
        len = i - s;
        if (len > bl) begin bl = len; bs = s; end
      end else i++;
    end
    err = (bl == 0);
    tap = err ? 0 : bs + bl / 2;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_state = 0; m_cnt = 0; m_tap = 0; m_lane = 0; m_done = 0; m_ok = 0;
      for (int i = 0; i < L; i++) begin exp_tap[i] = 0; exp_err[i] = 0; end
    end else begin
      case (m_state)
        0: if (start_i) begin
             m_state = 1; m_cnt = 0; m_tap = 0; m_lane = 0; m_done = 0;
           end
        1: if (m_cnt == SET - 1) begin m_cnt = 0; m_ok = 1; m_state = 2; end
           else m_cnt++;
        2: begin
             m_ok = m_ok & drive_bit();
             if (m_cnt == CHK - 1) begin
               rec[m_tap] = m_ok;
               m_cnt = 0;
               if (m_tap == TAPS - 1) m_state = 3;
               else begin m_tap++; m_state = 1; end
             end else m_cnt++;
           end
        default: begin
             pick_best(exp_tap[m_lane], exp_err[m_lane]);
             if (m_lane == L - 1) begin m_done = 1; m_state = 0; end
             else begin m_lane++; m_tap = 0; m_cnt = 0; m_state = 1; end
           end
      endcase
    end
  end

  // compare against the model and drive match flags away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk(cal_tap_o == TW'(m_tap), "R4 cal_tap_o", cal_tap_o, m_tap);
      chk(cal_lane_o == LW'(m_lane), "R7 cal_lane_o", cal_lane_o, m_lane);
      chk(done_o == m_done, "R8 done_o", done_o, m_done);
    end
    match_i = L'($urandom);
    match_i[m_lane] = drive_bit();
  end

  task automatic readback(input string tag);
    for (int l = 0; l < L; l++) begin
      rd_lane_i = LW'(l);
      #1;
      chk(rd_tap_o == TW'(exp_tap[l]), tag, rd_tap_o, exp_tap[l]);
      chk(rd_err_o == exp_err[l], tag, rd_err_o, exp_err[l]);
    end
  endtask

  task automatic run_pass();
    @(negedge clk); start_i = 1;
    @(negedge clk); start_i = 0;
    // start during calibration is ignored (R2)
    repeat (300) @(negedge clk);
    start_i = 1;
    @(negedge clk); start_i = 0;
    while (!done_o) @(negedge clk);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=done", cycles);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int l = 0; l < L; l++) pmap[l] = '0;
    repeat (3) @(negedge clk);
    // R1: reset values
    chk(done_o == 0, "R1 done", done_o, 0);
    chk(cal_tap_o == 0, "R1 tap", cal_tap_o, 0);
    chk(cal_lane_o == 0, "R1 lane", cal_lane_o, 0);
    readback("R1 readback");
    rst_n = 1;
    repeat (5) @(negedge clk);
    chk(done_o == 0, "R2 idle without start", done_o, 0);

    // pass 1: centred window, dead lane, tied windows, window at the top end
    pmap[0][20:10] = '1;                       // R5 -> 15
    pmap[1] = '0;                              // R6 -> error, tap 0
    pmap[2][8:5] = '1; pmap[2][33:30] = '1;    // R5 tie -> 7
    pmap[3][0] = 1'b1; pmap[3][63:50] = '1;    // R5 -> 57
    run_pass();
    readback("R5 R6 R9 pass1");
    chk(exp_tap[2] == 7 && exp_tap[3] == 57, "R5 model sanity", exp_tap[2], 7);
    repeat (40) @(negedge clk);
    chk(done_o == 1, "R8 done held", done_o, 1);
    readback("R9 hold");

    // pass 2: full window, glitch splits a window, single top tap, short run at zero
    for (int l = 0; l < L; l++) pmap[l] = '0;
    pmap[0] = '1;                              // -> 32
    pmap[1][40:20] = '1;                       // R10 glitch at 30 -> 25
    g_en = 1; g_lane = 1; g_tap = 30; g_cnt = 5;
    pmap[2][63] = 1'b1;                        // -> 63
    pmap[3][1:0] = '1;                         // -> 1
    run_pass();
    readback("R10 R5 R6 pass2");
    chk(exp_tap[1] == 25 && !exp_err[1], "R10 model sanity", exp_tap[1], 25);
    chk(exp_tap[0] == 32, "R5 full window", exp_tap[0], 32);

    repeat (5) @(negedge clk);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule